// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the device side of a three-wire serial control port that sits in front of a 32-row by 8-bit configuration store. A host lowers an active-low select line, clocks in an 18-bit command frame on a data line, and either commits a row write when it raises the select line again or receives the contents of one row on a return data line. Every writable row is also presented in parallel to the rest of the chip, and a set of status inputs supplies the contents of the read-only rows.

The three serial pins are oversampled by a free-running system clock through a synchronizer, so the serial clock is treated as data and the whole block lives in a single clock domain. An asynchronous active-low reset clears the store and abandons any frame in progress.

Top module: `serial_reg_slave`

## Requirements
- R1: The store holds 32 rows of 8 bits. Rows 0 to 9 and 16 to 23 are writable, and row r appears on `cfg_rows[8r+7:8r]`. Every other row reads as 0 on `cfg_rows`.
- R2: `ser_en_n` is active low. A frame starts when it falls, and `ser_data` is taken on each rising edge of `ser_clk` while it is low. The bit count returns to 0 whenever `ser_en_n` is high.
- R3: Frame bit k is the bit taken on the (k+1)-th rising edge. Bits 0 to 7 are the row data, LSB first. Bits 8 to 13 are the row address, LSB first. Bit 14 selects the direction (1 = write, 0 = read). Bits 15 to 17 are the device address, LSB first.
- R4: A frame whose device address is not 3'b111 has no effect: no row changes, and no data is returned.
- R5: A write changes no row before `ser_en_n` rises. The addressed row is loaded when `ser_en_n` rises.
- R6: A write is committed only if exactly 18 rising edges of `ser_clk` arrived while `ser_en_n` was low. With 17 or 19 edges, no row changes.
- R7: In a read frame, bit 0 of the addressed row is on `ser_out` after the 18th rising edge. Each of the next seven rising edges advances to the next bit. On the rising edge after bit 7 has been shown, `ser_out` returns to 0, and it also returns to 0 when `ser_en_n` rises early.
- R8: `ser_out` is 0 whenever no read is in progress, including for a read of an unused row (10 to 15, 28 to 31) or of an address of 32 or above.
- R9: Rows 24 to 27 are read-only status rows with the following contents. Row 24 is `{4'b0, st_mon}`. Row 25 is `st_tune_p`. Row 26 is `st_tune_n`. Row 27 is `{3'b0, st_temp}`. Writes to these rows are ignored.
- R10: Writes to an unused row or to a row address of 32 or above change nothing.
- R11: When `rst_n` goes low, every writable row is cleared to 0 at once, without waiting for a clock, and any frame in progress is abandoned.
- R12: All 8 bits of a writable row are stored and read back as written, including bits that have no function.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial command data, LSB first |
| ser_out | output | 1 | Serial read data, 0 when idle |
| st_mon | input | 4 | Lock and amplitude monitor bits for status row 24 |
| st_tune_p | input | 8 | Tuning monitor word for status row 25 |
| st_tune_n | input | 8 | Tuning monitor word for status row 26 |
| st_temp | input | 5 | Temperature code for status row 27 |
| cfg_rows | output | 256 | Parallel view of all rows, row r at bits 8r+7:8r |

## Verification
On every cycle, the bound checker verifies the following: the parallel rows change only in the cycle after a select release; a release with a wrong bit count or a wrong device address leaves the rows unchanged; the bit counter steps by one per serial edge and clears while the select is high; and `ser_out` falls quiet once the select is high. The bench scenarios are the only place where the rest is shown. This covers the frame bit order and field placement, the exact serial bit stream of a read, including its end after eight bits and its early cut-off, the contents of the status rows, the rejection of unused rows and out-of-range addresses, and the asynchronous clear in the middle of a frame.

// File: rtl/rsa_pkg.sv
package rsa_pkg;

  localparam int ROW_W      = 8;
  localparam int NUM_ROWS   = 32;
  localparam int ADDR_W     = 6;
  localparam int DEV_W      = 3;
  localparam int FRAME_BITS = ROW_W + ADDR_W + 1 + DEV_W;
  localparam logic [DEV_W-1:0] DEV_ID = 3'b111;

  // writable windows and status rows
  localparam int CFG_LO_END = 9;
  localparam int CFG_HI_BEG = 16;
  localparam int CFG_HI_END = 23;
  localparam int ROW_MON    = 24;
  localparam int ROW_TUNE_P = 25;
  localparam int ROW_TUNE_N = 26;
  localparam int ROW_TEMP   = 27;

  typedef enum logic [1:0] {
    ROW_CFG  = 2'd0,
    ROW_STS  = 2'd1,
    ROW_NONE = 2'd2
  } row_kind_e;

  // frame as seen after 18 right shifts: first bit ends up in bit 0
  typedef struct packed {
    logic [DEV_W-1:0]  dev;
    logic              wr;
    logic [ADDR_W-1:0] row;
    logic [ROW_W-1:0]  data;
  } frame_t;

  function automatic row_kind_e row_kind(input int unsigned idx);
    if (idx <= CFG_LO_END || (idx >= CFG_HI_BEG && idx <= CFG_HI_END))
      return ROW_CFG;
    else if (idx >= ROW_MON && idx <= ROW_TEMP)
      return ROW_STS;
    else
      return ROW_NONE;
  endfunction

endpackage

// File: rtl/rsa_in_sync.sv
module rsa_in_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] r;
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= RST_VAL;
          else        r <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= RST_VAL;
          else        r <= g_stage[g-1].r;
        end
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/rsa_pin_front.sv
module rsa_pin_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_en_n,
  input  logic ser_clk,
  input  logic ser_data,
  output logic en_hi,
  output logic en_rise,
  output logic sclk_rise,
  output logic data_s
);

  logic [2:0] pins_s;
  logic       en_d;
  logic       sclk_d;

  rsa_in_sync #(
    .STAGES (SYNC_STAGES),
    .W      (3),
    .RST_VAL(3'b001)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in ({ser_data, ser_clk, ser_en_n}),
    .q    (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      en_d   <= pins_s[0];
      sclk_d <= pins_s[1];
    end
  end

  assign en_hi     = pins_s[0];
  assign en_rise   = pins_s[0] & ~en_d;
  assign sclk_rise = pins_s[1] & ~sclk_d;
  assign data_s    = pins_s[2];

endmodule

// File: rtl/rsa_frame_rx.sv
module rsa_frame_rx #(
  parameter int FRAME_BITS = 18,
  parameter int CNT_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_hi,
  input  logic                  sclk_rise,
  input  logic                  data_s,
  output logic [FRAME_BITS-1:0] frame,
  output logic [CNT_W-1:0]      bit_cnt,
  output logic                  full_p
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      frame   <= '0;
      full_p  <= 1'b0;
    end else begin
      full_p <= 1'b0;
      if (en_hi) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt < CNT_FULL) frame <= {data_s, frame[FRAME_BITS-1:1]};
        if (bit_cnt == CNT_LAST) full_p <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rsa_reg_bank.sv
module rsa_reg_bank
  import rsa_pkg::*;
#(
  parameter int N_ROWS = 32,
  parameter int RW     = 8,
  parameter int AW     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [RW-1:0]        wdata,
  input  logic [AW-1:0]        raddr,
  input  logic [3:0]           st_mon,
  input  logic [7:0]           st_tune_p,
  input  logic [7:0]           st_tune_n,
  input  logic [4:0]           st_temp,
  output logic [N_ROWS*RW-1:0] cfg_flat,
  output logic [RW-1:0]        rd_data
);

  localparam int IDX_W = $clog2(N_ROWS);

  logic [RW-1:0] view [N_ROWS];

  genvar r;
  generate
    for (r = 0; r < N_ROWS; r++) begin : g_row
      localparam row_kind_e KIND = row_kind(r);
      if (KIND == ROW_CFG) begin : g_cfg
        logic [RW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                        q <= '0;
          else if (we && waddr == AW'(r))    q <= wdata;
        end
        assign view[r]                   = q;
        assign cfg_flat[r*RW +: RW]      = q;
      end else begin : g_fix
        assign cfg_flat[r*RW +: RW] = '0;
        if (r == ROW_MON) begin : g_mon
          assign view[r] = RW'(st_mon);
        end else if (r == ROW_TUNE_P) begin : g_tp
          assign view[r] = RW'(st_tune_p);
        end else if (r == ROW_TUNE_N) begin : g_tn
          assign view[r] = RW'(st_tune_n);
        end else if (r == ROW_TEMP) begin : g_tmp
          assign view[r] = RW'(st_temp);
        end else begin : g_none
          assign view[r] = '0;
        end
      end
    end
  endgenerate

  always_comb begin
    if (raddr < AW'(N_ROWS)) rd_data = view[raddr[IDX_W-1:0]];
    else                     rd_data = '0;
  end

endmodule

// File: rtl/rsa_readout.sv
module rsa_readout #(
  parameter int RW    = 8,
  parameter int LFT_W = $clog2(RW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_hi,
  input  logic          sclk_rise,
  input  logic          load,
  input  logic [RW-1:0] load_val,
  output logic          scan_out
);

  logic          active;
  logic [RW-1:0] sh;
  logic [LFT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sh     <= '0;
      left   <= '0;
    end else if (en_hi) begin
      active <= 1'b0;
    end else if (load) begin
      active <= 1'b1;
      sh     <= load_val;
      left   <= LFT_W'(RW - 1);
    end else if (active && sclk_rise) begin
      if (left == '0) begin
        active <= 1'b0;
      end else begin
        sh   <= {1'b0, sh[RW-1:1]};
        left <= left - 1'b1;
      end
    end
  end

  assign scan_out = active & sh[0];

endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
  import rsa_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_en_n,
  input  logic                     ser_clk,
  input  logic                     ser_data,
  output logic                     ser_out,
  input  logic [3:0]               st_mon,
  input  logic [7:0]               st_tune_p,
  input  logic [7:0]               st_tune_n,
  input  logic [4:0]               st_temp,
  output logic [NUM_ROWS*ROW_W-1:0] cfg_rows
);

  logic                  en_hi;
  logic                  en_rise;
  logic                  sclk_rise;
  logic                  data_s;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  full_p;
  logic [ROW_W-1:0]      rd_data;
  frame_t                fr;
  row_kind_e             kind;
  logic                  dev_ok;
  logic                  len_ok;
  logic                  wr_commit;
  logic                  rd_load;

  rsa_pin_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_en_n (ser_en_n),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .en_hi    (en_hi),
    .en_rise  (en_rise),
    .sclk_rise(sclk_rise),
    .data_s   (data_s)
  );

  rsa_frame_rx #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_hi    (en_hi),
    .sclk_rise(sclk_rise),
    .data_s   (data_s),
    .frame    (frame),
    .bit_cnt  (bit_cnt),
    .full_p   (full_p)
  );

  // decode of the shifted frame
  assign fr        = frame_t'(frame);
  assign kind      = row_kind(32'(fr.row));
  assign dev_ok    = (fr.dev == DEV_ID);
  assign len_ok    = (bit_cnt == CNT_W'(FRAME_BITS));
  assign wr_commit = en_rise & len_ok & dev_ok & fr.wr & (kind == ROW_CFG);
  assign rd_load   = full_p & dev_ok & ~fr.wr & (kind != ROW_NONE);

  rsa_reg_bank #(.N_ROWS(NUM_ROWS), .RW(ROW_W), .AW(ADDR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wr_commit),
    .waddr    (fr.row),
    .wdata    (fr.data),
    .raddr    (fr.row),
    .st_mon   (st_mon),
    .st_tune_p(st_tune_p),
    .st_tune_n(st_tune_n),
    .st_temp  (st_temp),
    .cfg_flat (cfg_rows),
    .rd_data  (rd_data)
  );

  rsa_readout #(.RW(ROW_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_hi    (en_hi),
    .sclk_rise(sclk_rise),
    .load     (rd_load),
    .load_val (rd_data),
    .scan_out (ser_out)
  );

endmodule

// File: rtl/rsa_checker.sv
module rsa_checker #(
  parameter int CNT_W = 6,
  parameter int FB    = 18,
  parameter int FLAT  = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_hi,
  input logic             en_rise,
  input logic             sclk_rise,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [FB-1:0]    frame,
  input logic [FLAT-1:0]  cfg_rows,
  input logic             ser_out
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_hi |=> !ser_out);

  assert_commit_on_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rise |=> $stable(cfg_rows));

  assert_exact_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && bit_cnt != CNT_W'(FB)) |=> $stable(cfg_rows));

  assert_dev_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && frame[FB-1:FB-3] != 3'b111) |=> $stable(cfg_rows));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !en_hi && bit_cnt != CMAX) |=> bit_cnt == CNT_W'($past(bit_cnt) + 1'b1));

  assert_count_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_hi |=> bit_cnt == '0);

endmodule

bind serial_reg_slave rsa_checker #(
  .CNT_W(CNT_W),
  .FB   (rsa_pkg::FRAME_BITS),
  .FLAT (rsa_pkg::NUM_ROWS * rsa_pkg::ROW_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_hi    (en_hi),
  .en_rise  (en_rise),
  .sclk_rise(sclk_rise),
  .bit_cnt  (bit_cnt),
  .frame    (frame),
  .cfg_rows (cfg_rows),
  .ser_out  (ser_out)
);

// File: tb/sim_serial_reg_slave.sv
module sim_serial_reg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_en_n = 1'b1;
  logic         ser_clk = 1'b0;
  logic         ser_data = 1'b0;
  logic         ser_out;
  logic [3:0]   st_mon = 4'h0;
  logic [7:0]   st_tune_p = 8'h00;
  logic [7:0]   st_tune_n = 8'h00;
  logic [4:0]   st_temp = 5'h00;
  logic [255:0] cfg_rows;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_reg_slave u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_en_n (ser_en_n),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_out  (ser_out),
    .st_mon   (st_mon),
    .st_tune_p(st_tune_p),
    .st_tune_n(st_tune_n),
    .st_temp  (st_temp),
    .cfg_rows (cfg_rows)
  );

  function automatic logic [17:0] mkf(input logic [7:0] d, input logic [5:0] row,
                                      input logic wr, input logic [2:0] dev);
    return {dev, wr, row, d};
  endfunction

  function automatic logic [255:0] model_flat();
    logic [255:0] v;
    for (int r = 0; r < 32; r++) v[r*8 +: 8] = model[r];
    return v;
  endfunction

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk_rows(input string req);
    n_chk++;
    if (cfg_rows !== model_flat()) begin
      n_bad++;
      $display("FAIL %s: actual %064h expected %064h", req, cfg_rows, model_flat());
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive nclk serial bits with ser_en_n low; captures read bits 0..7
  task automatic shift_frame(input logic [17:0] f, input int nclk, output logic [7:0] rd);
    rd = 8'h00;
    @(negedge clk);
    ser_en_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nclk; i++) begin
      ser_data = (i < 18) ? f[i] : 1'b0;
      wait_clk(HALF);
      if (i >= 18 && i < 26) rd[i-18] = ser_out;
      ser_clk = 1'b1;
      wait_clk(HALF);
      ser_clk = 1'b0;
    end
    wait_clk(HALF);
  endtask

  task automatic release_en();
    ser_en_n = 1'b1;
    wait_clk(4*HALF);
  endtask

  task automatic do_write(input string req, input logic [7:0] d, input logic [5:0] row,
                          input logic [2:0] dev, input int nclk, input bit takes);
    logic [7:0] rd;
    shift_frame(mkf(d, row, 1'b1, dev), nclk, rd);
    chk_rows({req, " R5 before release"});
    release_en();
    if (takes) model[row[4:0]] = d;
    chk_rows(req);
  endtask

  task automatic do_read(input string req, input logic [5:0] row, input logic [2:0] dev,
                         input logic [7:0] exp);
    logic [7:0] rd;
    shift_frame(mkf(8'h00, row, 1'b0, dev), 26, rd);
    chk8({req, " data"}, rd, exp);
    chk8({req, " R7 end quiet"}, {7'd0, ser_out}, 8'h00);
    release_en();
    chk_rows({req, " read leaves rows"});
  endtask

  task automatic t_reset();
    for (int r = 0; r < 32; r++) model[r] = 8'h00;
    wait_clk(3);
    chk_rows("R11 R1 reset state");
    chk8("R8 idle out", {7'd0, ser_out}, 8'h00);
    rst_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic t_write_read();
    do_write("R3 R5 R12 write row3", 8'hA5, 6'd3, 3'b111, 18, 1'b1);
    do_read("R7 R12 read row3", 6'd3, 3'b111, 8'hA5);
    do_write("R1 write row0", 8'h81, 6'd0, 3'b111, 18, 1'b1);
    do_write("R1 write row9", 8'h7E, 6'd9, 3'b111, 18, 1'b1);
    do_write("R1 write row16", 8'h3C, 6'd16, 3'b111, 18, 1'b1);
    do_write("R1 write row23", 8'hF0, 6'd23, 3'b111, 18, 1'b1);
    do_read("R12 read row23", 6'd23, 3'b111, 8'hF0);
    do_read("R3 read row0", 6'd0, 3'b111, 8'h81);
  endtask

  task automatic t_rejects();
    do_write("R10 write unused row10", 8'hFF, 6'd10, 3'b111, 18, 1'b0);
    do_write("R10 write unused row31", 8'hFF, 6'd31, 3'b111, 18, 1'b0);
    do_write("R10 write row40", 8'hFF, 6'd40, 3'b111, 18, 1'b0);
    do_write("R9 write status row24", 8'hFF, 6'd24, 3'b111, 18, 1'b0);
    do_write("R4 wrong device", 8'h55, 6'd3, 3'b110, 18, 1'b0);
    do_write("R6 17 bits", 8'h55, 6'd3, 3'b111, 17, 1'b0);
    do_write("R6 19 bits", 8'h55, 6'd3, 3'b111, 19, 1'b0);
  endtask

  task automatic t_status();
    st_mon = 4'hB; st_tune_p = 8'h3C; st_tune_n = 8'hC6; st_temp = 5'h15;
    wait_clk(2);
    do_read("R9 row24", 6'd24, 3'b111, 8'h0B);
    do_read("R9 row25", 6'd25, 3'b111, 8'h3C);
    do_read("R9 row26", 6'd26, 3'b111, 8'hC6);
    do_read("R9 row27", 6'd27, 3'b111, 8'h15);
  endtask

  task automatic t_quiet_reads();
    logic [7:0] rd;
    do_read("R8 read unused row12", 6'd12, 3'b111, 8'h00);
    do_read("R8 read row50", 6'd50, 3'b111, 8'h00);
    do_read("R4 R8 read wrong device", 6'd3, 3'b011, 8'h00);
    do_write("R7 prep row5", 8'hFF, 6'd5, 3'b111, 18, 1'b1);
    shift_frame(mkf(8'h00, 6'd5, 1'b0, 3'b111), 20, rd);
    chk8("R7 early bits", rd, 8'h03);
    release_en();
    chk8("R7 R8 quiet after early release", {7'd0, ser_out}, 8'h00);
  endtask

  task automatic t_async_reset();
    logic [7:0] rd;
    shift_frame(mkf(8'h99, 6'd7, 1'b1, 3'b111), 10, rd);
    #3 rst_n = 1'b0;
    #1;
    for (int r = 0; r < 32; r++) model[r] = 8'h00;
    chk_rows("R11 async clear");
    wait_clk(2);
    rst_n = 1'b1;
    ser_en_n = 1'b1;
    wait_clk(4*HALF);
    chk_rows("R11 aborted frame");
    do_write("R11 write after reset", 8'h42, 6'd7, 3'b111, 18, 1'b1);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_rejects();
    t_status();
    t_quiet_reads();
    t_async_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule